// File: doc/BRIEF.md
# Four-Bit Two-Register Processor Core

This block is a very small processor core. Its program memory is kept apart from its data. The core holds two 4-bit working registers, which it uses both as operands and as destinations. It also has a 4-bit display latch, a 4-bit input port, a 4-bit program counter and a single overflow flag. Each clock cycle it fetches one 8-bit word from a 16-word program store, decodes it and executes it. Bits [7:4] of the word select the operation. Bits [3:0] hold an immediate value or a jump target.

The program is written through a load port while the core is held in reset. After reset is released the core runs by itself. It reads the input port when told to, and it shows results by copying a register into the display latch. The only branch condition is the overflow flag, and the conditional jump is taken when the flag is clear. This lets a loop run until an addition overflows.

Top module: `nib_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, both working registers, the display latch and the overflow flag are all cleared to zero.
- R2: A program word is written at `ld_addr` only when both `ld_we` and `rst` are high at a rising edge. A write attempted while `rst` is low leaves the program store unchanged.
- R3: With `rst` low, one instruction executes per rising edge. When no jump is taken, the program counter advances by one modulo 16, so 15 is followed by 0.
- R4: The register transfers work as follows. Opcode 1 loads the immediate into A and opcode 2 loads it into B. Opcode 3 copies B into A and opcode 4 copies A into B. Opcode A loads `in_port` into A and opcode B loads `in_port` into B.
- R5: Opcode 5 writes (A+B) mod 16 into A and opcode 6 writes (A+B) mod 16 into B. Both set the flag to the carry out of bit 3.
- R6: Opcode 7 writes A AND B into A, opcode 8 writes A XOR B into A and opcode 9 writes A OR B into A. Each of these clears the flag.
- R7: Opcodes 0-4 and A-F leave the overflow flag unchanged.
- R8: Opcode C copies A to `disp_o` and opcode D copies B to `disp_o`. Every other opcode leaves `disp_o` unchanged.
- R9: Opcode E loads the immediate into the program counter.
- R10: Opcode F loads the immediate into the program counter when the flag is 0. When the flag is 1 it falls through to the next word.
- R11: The low nibble is ignored by opcodes 0, 3, 4, 5-9, A, B, C and D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| ld_we | input | 1 | Program store write enable (honoured only in reset) |
| ld_addr | input | AW (4) | Program store write address |
| ld_data | input | 8 | Program word: opcode in [7:4], operand in [3:0] |
| in_port | input | DW (4) | External input value |
| disp_o | output | DW (4) | Display latch |
| pc_o | output | AW (4) | Program counter (address of the next instruction) |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench first targets additions that carry out of bit 3. A core that failed to wrap would show wrong register values, and a core with a wrong flag would leave the Fibonacci loop one step early or late. It then checks that a logic operation clears a flag that was set, and that moves and display writes keep the flag. A core that updated the flag on every opcode would take the conditional jump wrongly. Further cases cover the conditional jump both taken and not taken, program counter wraparound after word 15, junk bits in the low nibble of operand-free opcodes, and load writes attempted outside reset. A core that accepted those writes would change its program. Randomly generated programs with a changing input are compared cycle by cycle against a reference model in the bench.

// File: rtl/nib_pkg.sv
package nib_pkg;

   typedef enum logic [3:0] {
      OP_NOP  = 4'h0,
      OP_LDA  = 4'h1,
      OP_LDB  = 4'h2,
      OP_B2A  = 4'h3,
      OP_A2B  = 4'h4,
      OP_ADDA = 4'h5,
      OP_ADDB = 4'h6,
      OP_ANDA = 4'h7,
      OP_XORA = 4'h8,
      OP_ORA  = 4'h9,
      OP_INA  = 4'hA,
      OP_INB  = 4'hB,
      OP_SHWA = 4'hC,
      OP_SHWB = 4'hD,
      OP_JMP  = 4'hE,
      OP_JNV  = 4'hF
   } op_e;

   typedef enum logic [1:0] {
      FN_ADD,
      FN_AND,
      FN_OR,
      FN_XOR
   } alu_fn_e;

   typedef enum logic [1:0] {
      SRC_IMM,
      SRC_PEER,
      SRC_ALU,
      SRC_IN
   } src_e;

   typedef struct packed {
      logic    wr_a;
      src_e    a_src;
      logic    wr_b;
      src_e    b_src;
      logic    wr_disp;
      logic    disp_from_b;
      alu_fn_e fn;
      logic    flag_we;
      logic    jump;
      logic    jump_if_clr;
   } ctl_t;

endpackage

// File: rtl/nib_store.sv
module nib_store #(
   parameter int AW = 4,
   parameter int IW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [IW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [IW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [IW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/nib_decode.sv
module nib_decode
   import nib_pkg::*;
(
   input  op_e  op,
   output ctl_t ctl
);
   always_comb begin
      ctl             = '0;
      ctl.a_src       = SRC_IMM;
      ctl.b_src       = SRC_IMM;
      ctl.fn          = FN_ADD;
      unique case (op)
         OP_NOP:  ;
         OP_LDA:  begin ctl.wr_a = 1'b1; ctl.a_src = SRC_IMM;  end
         OP_LDB:  begin ctl.wr_b = 1'b1; ctl.b_src = SRC_IMM;  end
         OP_B2A:  begin ctl.wr_a = 1'b1; ctl.a_src = SRC_PEER; end
         OP_A2B:  begin ctl.wr_b = 1'b1; ctl.b_src = SRC_PEER; end
         OP_ADDA: begin ctl.wr_a = 1'b1; ctl.a_src = SRC_ALU; ctl.fn = FN_ADD; ctl.flag_we = 1'b1; end
         OP_ADDB: begin ctl.wr_b = 1'b1; ctl.b_src = SRC_ALU; ctl.fn = FN_ADD; ctl.flag_we = 1'b1; end
         OP_ANDA: begin ctl.wr_a = 1'b1; ctl.a_src = SRC_ALU; ctl.fn = FN_AND; ctl.flag_we = 1'b1; end
         OP_XORA: begin ctl.wr_a = 1'b1; ctl.a_src = SRC_ALU; ctl.fn = FN_XOR; ctl.flag_we = 1'b1; end
         OP_ORA:  begin ctl.wr_a = 1'b1; ctl.a_src = SRC_ALU; ctl.fn = FN_OR;  ctl.flag_we = 1'b1; end
         OP_INA:  begin ctl.wr_a = 1'b1; ctl.a_src = SRC_IN;   end
         OP_INB:  begin ctl.wr_b = 1'b1; ctl.b_src = SRC_IN;   end
         OP_SHWA: begin ctl.wr_disp = 1'b1; end
         OP_SHWB: begin ctl.wr_disp = 1'b1; ctl.disp_from_b = 1'b1; end
         OP_JMP:  begin ctl.jump = 1'b1; end
         OP_JNV:  begin ctl.jump = 1'b1; ctl.jump_if_clr = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
   import nib_pkg::*;
#(
   parameter int DW     = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  alu_fn_e       fn,
   output logic [DW-1:0] res,
   output logic          ovf
);
   logic [DW-1:0] sum;
   logic          cout;

   generate
      if (RIPPLE) begin : g_ripple
         always_comb begin
            logic c;
            c = 1'b0;
            for (int i = 0; i < DW; i++) begin
               sum[i] = a[i] ^ b[i] ^ c;
               c      = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
            end
            cout = c;
         end
      end else begin : g_flat
         assign {cout, sum} = {1'b0, a} + {1'b0, b};
      end
   endgenerate

   always_comb begin
      res = sum;
      ovf = 1'b0;
      unique case (fn)
         FN_ADD: begin res = sum; ovf = cout; end
         FN_AND: res = a & b;
         FN_OR:  res = a | b;
         FN_XOR: res = a ^ b;
         default: ;
      endcase
   end
endmodule

// File: rtl/nib_core.sv
module nib_core
   import nib_pkg::*;
#(
   parameter int DW         = 4,
   parameter int AW         = 4,
   parameter int OPW        = 4,
   parameter bit ALU_RIPPLE = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ld_we,
   input  logic [AW-1:0]       ld_addr,
   input  logic [OPW+DW-1:0]   ld_data,
   input  logic [DW-1:0]       in_port,
   output logic [DW-1:0]       disp_o,
   output logic [AW-1:0]       pc_o,
   output logic                ovf_o
);
   localparam int IW = OPW + DW;

   generate
      if (AW != DW) begin : g_bad_aw
         $error("nib_core: jump targets come from the operand field, AW must equal DW");
      end
      if (OPW != 4) begin : g_bad_opw
         $error("nib_core: the decoder needs a 4-bit opcode field");
      end
   endgenerate

   logic [AW-1:0] pc_q;
   logic [DW-1:0] ra_q, rb_q, disp_q;
   logic          ovf_q;

   logic [IW-1:0]  instr;
   logic [OPW-1:0] op_raw;
   logic [DW-1:0]  imm;
   ctl_t           ctl;
   logic [DW-1:0]  alu_res;
   logic           alu_ovf;
   logic [DW-1:0]  a_nx, b_nx;
   logic           take;

   nib_store #(.AW(AW), .IW(IW)) u_store (
      .clk   (clk),
      .we    (ld_we & rst),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (pc_q),
      .rdata (instr)
   );

   assign op_raw = instr[IW-1 -: OPW];
   assign imm    = instr[DW-1:0];

   nib_decode u_dec (
      .op  (op_e'(op_raw)),
      .ctl (ctl)
   );

   nib_alu #(.DW(DW), .RIPPLE(ALU_RIPPLE)) u_alu (
      .a   (ra_q),
      .b   (rb_q),
      .fn  (ctl.fn),
      .res (alu_res),
      .ovf (alu_ovf)
   );

   always_comb begin
      unique case (ctl.a_src)
         SRC_IMM:  a_nx = imm;
         SRC_PEER: a_nx = rb_q;
         SRC_ALU:  a_nx = alu_res;
         SRC_IN:   a_nx = in_port;
         default:  a_nx = ra_q;
      endcase
      unique case (ctl.b_src)
         SRC_IMM:  b_nx = imm;
         SRC_PEER: b_nx = ra_q;
         SRC_ALU:  b_nx = alu_res;
         SRC_IN:   b_nx = in_port;
         default:  b_nx = rb_q;
      endcase
   end

   assign take = ctl.jump & (~ctl.jump_if_clr | ~ovf_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= '0;
         ra_q   <= '0;
         rb_q   <= '0;
         disp_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         pc_q <= take ? AW'(imm) : pc_q + 1'b1;
         if (ctl.wr_a)    ra_q   <= a_nx;
         if (ctl.wr_b)    rb_q   <= b_nx;
         if (ctl.wr_disp) disp_q <= ctl.disp_from_b ? rb_q : ra_q;
         if (ctl.flag_we) ovf_q  <= alu_ovf;
      end
   end

   assign disp_o = disp_q;
   assign pc_o   = pc_q;
   assign ovf_o  = ovf_q;
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk #(
   parameter int DW = 4,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst,
   input logic [3:0]    op,
   input logic [DW-1:0] imm,
   input logic [DW-1:0] disp_o,
   input logic [AW-1:0] pc_o,
   input logic          ovf_o
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (pc_o == '0 && disp_o == '0 && !ovf_o));

   // R3
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (op != 4'hE && op != 4'hF) |=> pc_o == $past(pc_o) + 1'b1);

   // R9
   jump_always_chk: assert property (@(posedge clk) disable iff (rst)
      (op == 4'hE) |=> pc_o == AW'($past(imm)));

   // R10
   jump_clr_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (op == 4'hF && !ovf_o) |=> pc_o == AW'($past(imm)));

   // R10
   jump_set_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (op == 4'hF && ovf_o) |=> pc_o == $past(pc_o) + 1'b1);

   // R6
   logic_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (op == 4'h7 || op == 4'h8 || op == 4'h9) |=> !ovf_o);

   // R7
   flag_kept_chk: assert property (@(posedge clk) disable iff (rst)
      (op < 4'h5 || op > 4'h9) |=> $stable(ovf_o));

   // R8
   disp_kept_chk: assert property (@(posedge clk) disable iff (rst)
      (op != 4'hC && op != 4'hD) |=> $stable(disp_o));
endmodule

bind nib_core nib_core_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .op     (op_raw),
   .imm    (imm),
   .disp_o (disp_o),
   .pc_o   (pc_o),
   .ovf_o  (ovf_o)
);

// File: tb/tb_nib_core.sv
`timescale 1ns/1ps
module tb_nib_core;
   localparam int DW = 4;
   localparam int AW = 4;
   localparam int IW = 8;
   localparam int N  = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ld_we = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [IW-1:0] ld_data = '0;
   logic [DW-1:0] in_port = '0;
   logic [DW-1:0] disp_o;
   logic [AW-1:0] pc_o;
   logic          ovf_o;

   always #10 clk = ~clk;

   nib_core dut (
      .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .in_port(in_port), .disp_o(disp_o), .pc_o(pc_o), .ovf_o(ovf_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] pgm [N];
   logic [3:0] m_pc, m_a, m_b, m_d;
   logic       m_f;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] ref_add(input logic [3:0] x, input logic [3:0] y);
      return {1'b0, x} + {1'b0, y};
   endfunction

   task automatic model_step(input logic [3:0] inp);
      logic [3:0] op, im;
      logic [4:0] s;
      logic [3:0] nxt;
      op  = pgm[m_pc][7:4];
      im  = pgm[m_pc][3:0];
      nxt = m_pc + 4'd1;
      s   = ref_add(m_a, m_b);
      case (op)
         4'h1: m_a = im;
         4'h2: m_b = im;
         4'h3: m_a = m_b;
         4'h4: m_b = m_a;
         4'h5: begin m_a = s[3:0]; m_f = s[4]; end
         4'h6: begin m_b = s[3:0]; m_f = s[4]; end
         4'h7: begin m_a = m_a & m_b; m_f = 1'b0; end
         4'h8: begin m_a = m_a ^ m_b; m_f = 1'b0; end
         4'h9: begin m_a = m_a | m_b; m_f = 1'b0; end
         4'hA: m_a = inp;
         4'hB: m_b = inp;
         4'hC: m_d = m_a;
         4'hD: m_d = m_b;
         4'hE: nxt = im;
         4'hF: if (!m_f) nxt = im;
         default: ;
      endcase
      m_pc = nxt;
   endtask

   task automatic load_and_reset();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < N; i++) begin
         ld_we = 1'b1; ld_addr = i[3:0]; ld_data = pgm[i];
         @(negedge clk);
      end
      ld_we = 1'b0;
      @(negedge clk);
      // R1: state cleared while in reset
      chk("R1 pc", {4'h0, pc_o}, 8'h0);
      chk("R1 disp", {4'h0, disp_o}, 8'h0);
      chk("R1 flag", {7'h0, ovf_o}, 8'h0);
      rst = 1'b0;
      m_pc = '0; m_a = '0; m_b = '0; m_d = '0; m_f = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_pgm();
      for (int i = 0; i < N; i++) pgm[i] = 8'h00;
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_up();
   end

   initial begin
      logic [3:0] seen [$];
      logic [3:0] last;
      void'($urandom(32'd20240));

      // R1: registers read back as zero right after reset
      clear_pgm();
      pgm[0] = 8'hC0; pgm[1] = 8'hD0; pgm[2] = 8'hE2;
      load_and_reset();
      run(1);
      chk("R1 A zero", {4'h0, disp_o}, 8'h0);
      run(1);
      chk("R1 B zero", {4'h0, disp_o}, 8'h0);

      // R3: wraparound with all NOPs
      clear_pgm();
      load_and_reset();
      run(15);
      chk("R3 pc at 15", {4'h0, pc_o}, 8'h0F);
      run(2);
      chk("R3 pc wrap", {4'h0, pc_o}, 8'h01);

      // R5 / R7 / R8 / R9
      clear_pgm();
      pgm[0] = 8'h1F; pgm[1] = 8'h21; pgm[2] = 8'h50; pgm[3] = 8'hC0;
      pgm[4] = 8'h60; pgm[5] = 8'hD0; pgm[6] = 8'hE6;
      load_and_reset();
      run(3);
      chk("R5 carry sets flag", {7'h0, ovf_o}, 8'h1);
      run(1);
      chk("R5 sum wraps", {4'h0, disp_o}, 8'h0);
      chk("R7 display write keeps flag", {7'h0, ovf_o}, 8'h1);
      run(2);
      chk("R5 no carry clears flag", {7'h0, ovf_o}, 8'h0);
      chk("R8 show B", {4'h0, disp_o}, 8'h1);
      run(3);
      chk("R9 jump holds pc", {4'h0, pc_o}, 8'h6);
      chk("R8 display held", {4'h0, disp_o}, 8'h1);

      // R6 / R7
      clear_pgm();
      pgm[0] = 8'h1F; pgm[1] = 8'h21; pgm[2] = 8'h50; pgm[3] = 8'h1C;
      pgm[4] = 8'h2A; pgm[5] = 8'h70; pgm[6] = 8'hC0; pgm[7] = 8'h80;
      pgm[8] = 8'hC0; pgm[9] = 8'h90; pgm[10] = 8'hC0; pgm[11] = 8'hEB;
      load_and_reset();
      run(5);
      chk("R7 loads keep flag", {7'h0, ovf_o}, 8'h1);
      run(1);
      chk("R6 AND clears flag", {7'h0, ovf_o}, 8'h0);
      run(1);
      chk("R6 AND result", {4'h0, disp_o}, 8'h8);
      run(2);
      chk("R6 XOR result", {4'h0, disp_o}, 8'h2);
      run(2);
      chk("R6 OR result", {4'h0, disp_o}, 8'hA);

      // R4 / R10 / R11
      clear_pgm();
      pgm[0] = 8'h1F; pgm[1] = 8'h21; pgm[2] = 8'h50; pgm[3] = 8'hF8;
      pgm[4] = 8'hB7; pgm[5] = 8'hDF; pgm[6] = 8'hF8; pgm[7] = 8'h70;
      pgm[8] = 8'hFC; pgm[9] = 8'hC0; pgm[10] = 8'hC0; pgm[11] = 8'hC0;
      pgm[12] = 8'h3A; pgm[13] = 8'hC5; pgm[14] = 8'hEE;
      load_and_reset();
      in_port = 4'h6;
      run(4);
      chk("R10 flag set falls through", {4'h0, pc_o}, 8'h4);
      run(2);
      chk("R4 input to B", {4'h0, disp_o}, 8'h6);
      run(1);
      chk("R10 second fall through", {4'h0, pc_o}, 8'h7);
      run(2);
      chk("R10 flag clear jumps", {4'h0, pc_o}, 8'hC);
      run(2);
      chk("R11 junk operand ignored", {4'h0, disp_o}, 8'h6);
      run(3);
      chk("R9 self loop", {4'h0, pc_o}, 8'hE);

      // R2: load port ignored outside reset
      clear_pgm();
      pgm[0] = 8'h17; pgm[1] = 8'hC0; pgm[2] = 8'hE2;
      load_and_reset();
      run(3);
      chk("R4 immediate to A", {4'h0, disp_o}, 8'h7);
      ld_we = 1'b1; ld_addr = 4'h0; ld_data = 8'h13;
      @(negedge clk);
      ld_we = 1'b0;
      rst = 1'b1;
      run(2);
      rst = 1'b0;
      run(3);
      chk("R2 write outside reset ignored", {4'h0, disp_o}, 8'h7);

      // Fibonacci loop until overflow (R5, R10)
      clear_pgm();
      pgm[0] = 8'h10; pgm[1] = 8'h21; pgm[2] = 8'h50; pgm[3] = 8'hF5;
      pgm[4] = 8'hE4; pgm[5] = 8'hC0; pgm[6] = 8'h60; pgm[7] = 8'hF9;
      pgm[8] = 8'hE8; pgm[9] = 8'hD0; pgm[10] = 8'hE2;
      load_and_reset();
      last = disp_o;
      for (int c = 0; c < 80; c++) begin
         @(negedge clk);
         if (disp_o !== last) begin
            seen.push_back(disp_o);
            last = disp_o;
         end
      end
      chk("R5 fib count", 8'(seen.size()), 8'd6);
      begin
         logic [3:0] fib_exp [6];
         fib_exp = '{4'd1, 4'd2, 4'd3, 4'd5, 4'd8, 4'd13};
         for (int k = 0; k < 6; k++)
            chk("R8 fib value", (k < seen.size()) ? {4'h0, seen[k]} : 8'hFF, {4'h0, fib_exp[k]});
      end
      chk("R10 fib halts", {4'h0, pc_o}, 8'h4);
      chk("R5 fib overflow flag", {7'h0, ovf_o}, 8'h1);

      // Random programs against the bench model (R3..R11)
      for (int p = 0; p < 20; p++) begin
         for (int i = 0; i < N; i++) pgm[i] = 8'($urandom);
         load_and_reset();
         for (int c = 0; c < 40; c++) begin
            chk("R3 random pc", {4'h0, pc_o}, {4'h0, m_pc});
            chk("R8 random disp", {4'h0, disp_o}, {4'h0, m_d});
            chk("R5 random flag", {7'h0, ovf_o}, {7'h0, m_f});
            in_port = 4'($urandom);
            model_step(in_port);
            @(negedge clk);
         end
      end

      finish_up();
   end
endmodule